// File: doc/BRIEF.md
# Timer capture/compare status flag unit

This block is the status section of one 16-bit timer channel. A free-running up-counter advances on a count-enable input. It feeds four general registers, numbered 0 to 3. Each general register is set up separately in one of two modes:

- **Compare mode:** the register raises its event when the counter ticks while holding the register's value.
- **Capture mode:** a selected edge on that register's capture pin, taken through a synchronizer, loads the counter value into the register and raises the event.

Each event, and the counter wrap, sets a sticky flag. Software sees the flags as one 8-bit status word on a simple strobe bus.

A flag clears in one of two ways. Software may write 0 to it, but only after a status read has returned 1 for that flag. The four capture/compare flags can also be cleared by an acknowledge from an external transfer engine, unless a no-clear mode input is high. Each flag, gated by its own bit in an enable register, drives an interrupt request output. Prescaling, counter clearing, waveform pins and the transfer engine itself are outside the block.

Top module: `tmr_flag_unit`

## Requirements
- R1: `cnt_q` rises by one (modulo 2^16) on each clock edge where `cnt_en` is 1, and holds otherwise. All state resets to 0.
- R2: The wrap flag (status bit 4) becomes 1 after the edge where `cnt_en` is 1 and `cnt_q` is 0xFFFF.
- R3: In compare mode (`gr_cap_mode[i]`=0), flag i (status bit i) becomes 1 after an edge where `cnt_en` is 1 and `cnt_q` equals register i.
- R4: In capture mode (`gr_cap_mode[i]`=1), register i takes a qualifying edge of `cap_in[i]` two edges after the pin changes. It loads the counter value present before that edge and sets flag i. The edge select `cap_edge_sel[2i+1:2i]` is 00 for rising, 01 for falling, and 10 or 11 for both. A non-qualifying edge changes nothing.
- R5: `sts_rdata` reads as 1 in bits 7 and 6 and as 0 in bit 5. Bit 4 is the wrap flag, and bits 3..0 are flags 3..0.
- R6: A status write with `bus_wdata[b]`=0 clears flag b only if an earlier `sts_rd` returned 1 for it. Writing 1 has no effect. Clearing a flag disarms it.
- R7: `xfer_ack[i]` clears flag i when `xfer_noclr` is 0 and has no effect when `xfer_noclr` is 1.
- R8: When a set and a clear of the same flag fall on the same edge, the flag stays 1.
- R9: `irq[b]` is flag b AND enable bit b. The enable register is loaded from `bus_wdata[4:0]` by `ien_wr`, using the same bit layout as the status word.
- R10: While reset is asserted, `sts_rdata` is 0xC0, `irq` is 0, and the counter and the general registers read 0.
- R11: `gr_wr` loads `gr_wdata` into the register chosen by `gr_wr_sel`. A capture on the same edge takes precedence. `gr_rdata` shows the register chosen by `gr_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| gr_wr | input | 1 | General register write strobe |
| gr_wr_sel | input | 2 | General register written |
| gr_wdata | input | 16 | General register write data |
| gr_rd_sel | input | 2 | General register shown on gr_rdata |
| gr_rdata | output | 16 | Selected general register |
| gr_cap_mode | input | 4 | Per-register mode, 1 = capture |
| cap_edge_sel | input | 8 | Two edge-select bits per register |
| cap_in | input | 4 | Asynchronous capture pins |
| sts_rd | input | 1 | Status read strobe |
| sts_wr | input | 1 | Status write strobe |
| ien_wr | input | 1 | Enable register write strobe |
| bus_wdata | input | 5 | Write data for status and enable registers |
| sts_rdata | output | 8 | Status word |
| xfer_ack | input | 4 | Transfer engine acknowledge, per flag |
| xfer_noclr | input | 1 | 1 = acknowledges leave flags set |
| irq | output | 5 | Interrupt requests, status layout |
| cnt_q | output | 16 | Counter value |

## Verification
On every cycle, the assertions check:
- the counter step and hold;
- that a wrap sets the wrap flag;
- the constant bits of the status word;
- that an interrupt never appears without its flag;
- that no flag drops unless a 0-write or an enabled acknowledge is present.

Some behaviour depends on the read history and on event timing, and only the bench's scenarios show it. This covers:
- that an unread flag ignores a 0-write;
- that a set beats a simultaneous clear;
- the synchronizer latency and the value loaded by a capture;
- the edge-select encodings.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
   localparam int NUM_CC    = 4;
   localparam int FLAG_W    = NUM_CC + 1;
   localparam int OVF_BIT   = NUM_CC;
   localparam int SEL_W     = $clog2(NUM_CC);
   localparam int STS_W     = 8;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_ANY  = 2'b10,
      EDGE_ANY2 = 2'b11
   } edge_sel_e;

   function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
      case (sel)
         EDGE_RISE: edge_hit = cur & ~prev;
         EDGE_FALL: edge_hit = ~cur & prev;
         default:   edge_hit = cur ^ prev;
      endcase
   endfunction
endpackage

// File: rtl/tfu_counter.sv
module tfu_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   output logic [CNT_W-1:0] q_o,
   output logic             wrap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else if (en_i) q_o <= q_o + CNT_W'(1);
   end

   assign wrap_o = en_i & (&q_o);
endmodule

// File: rtl/tfu_edge_det.sv
module tfu_edge_det
   import tfu_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sel_i,
   output logic       hit_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign hit_o = edge_hit(edge_sel_e'(sel_i), sync_q[SYNC_STAGES-1], prev_q);
endmodule

// File: rtl/tfu_gr_chan.sv
module tfu_gr_chan #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cnt_en_i,
   input  logic             cap_mode_i,
   input  logic [1:0]       edge_sel_i,
   input  logic             cap_pin_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] gr_o,
   output logic             event_o
);
   logic pin_hit;
   logic capture;
   logic match;

   tfu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (cap_pin_i),
      .sel_i (edge_sel_i),
      .hit_o (pin_hit)
   );

   assign capture = cap_mode_i & pin_hit;
   assign match   = ~cap_mode_i & cnt_en_i & (cnt_i == gr_o);
   assign event_o = capture | match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gr_o <= '0;
      else if (capture) gr_o <= cnt_i;
      else if (wr_i)    gr_o <= wdata_i;
   end
endmodule

// File: rtl/tfu_flag_cell.sv
module tfu_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr0_i,
   input  logic ack_clr_i,
   input  logic rd_i,
   output logic flag_o
);
   logic armed_q;
   logic clr;
   logic drop;

   assign clr  = (wr0_i & armed_q) | ack_clr_i;
   assign drop = clr & ~set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         flag_o <= set_i | (flag_o & ~clr);
         if (drop)                 armed_q <= 1'b0;
         else if (rd_i & flag_o)   armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
   import tfu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_en,
   input  logic                gr_wr,
   input  logic [1:0]          gr_wr_sel,
   input  logic [CNT_W-1:0]    gr_wdata,
   input  logic [1:0]          gr_rd_sel,
   output logic [CNT_W-1:0]    gr_rdata,
   input  logic [3:0]          gr_cap_mode,
   input  logic [7:0]          cap_edge_sel,
   input  logic [3:0]          cap_in,
   input  logic                sts_rd,
   input  logic                sts_wr,
   input  logic                ien_wr,
   input  logic [4:0]          bus_wdata,
   output logic [7:0]          sts_rdata,
   input  logic [3:0]          xfer_ack,
   input  logic                xfer_noclr,
   output logic [4:0]          irq,
   output logic [CNT_W-1:0]    cnt_q
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr_flag_unit: CNT_W must lie in 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_flag_unit: SYNC_STAGES must be at least 2");
   end

   logic                 wrap;
   logic [NUM_CC-1:0]    cc_evt;
   logic [CNT_W-1:0]     gr_q [NUM_CC];
   logic [FLAG_W-1:0]    flags;
   logic [FLAG_W-1:0]    ien_q;
   logic [FLAG_W-1:0]    set_vec;

   tfu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cnt_en),
      .q_o    (cnt_q),
      .wrap_o (wrap)
   );

   for (genvar i = 0; i < NUM_CC; i++) begin : g_chan
      tfu_gr_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cnt_i      (cnt_q),
         .cnt_en_i   (cnt_en),
         .cap_mode_i (gr_cap_mode[i]),
         .edge_sel_i (cap_edge_sel[2*i +: 2]),
         .cap_pin_i  (cap_in[i]),
         .wr_i       (gr_wr && (gr_wr_sel == SEL_W'(i))),
         .wdata_i    (gr_wdata),
         .gr_o       (gr_q[i]),
         .event_o    (cc_evt[i])
      );
   end

   assign set_vec = {wrap, cc_evt};

   for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
      logic ack_clr;
      if (f == OVF_BIT) begin : g_wrap_src
         assign ack_clr = 1'b0;
      end else begin : g_cc_src
         assign ack_clr = xfer_ack[f] & ~xfer_noclr;
      end
      tfu_flag_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (set_vec[f]),
         .wr0_i     (sts_wr & ~bus_wdata[f]),
         .ack_clr_i (ack_clr),
         .rd_i      (sts_rd),
         .flag_o    (flags[f])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_wr) ien_q <= bus_wdata;
   end

   assign irq       = flags & ien_q;
   assign sts_rdata = {2'b11, 1'b0, flags};
   assign gr_rdata  = gr_q[gr_rd_sel];
endmodule

// File: rtl/tfu_chk.sv
module tfu_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             sts_wr,
   input logic [4:0]       bus_wdata,
   input logic [7:0]       sts_rdata,
   input logic [3:0]       xfer_ack,
   input logic             xfer_noclr,
   input logic [4:0]       irq,
   input logic [CNT_W-1:0] cnt_q
);
   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

   assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_q));

   assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && (&cnt_q)) |=> sts_rdata[4]);

   assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sts_rdata[7:5] == 3'b110);

   assert_wrap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rdata[4] && !(sts_wr && !bus_wdata[4])) |=> sts_rdata[4]);

   for (genvar i = 0; i < 4; i++) begin : g_cc
      assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_rdata[i] && !(sts_wr && !bus_wdata[i]) && !(xfer_ack[i] && !xfer_noclr))
         |=> sts_rdata[i]);
   end

   for (genvar b = 0; b < 5; b++) begin : g_irq
      assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq[b] |-> sts_rdata[b]);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_state_R10: assert (sts_rdata == 8'hC0 && irq == 5'd0);
      end
   end
endmodule

bind tmr_flag_unit tfu_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_en     (cnt_en),
   .sts_wr     (sts_wr),
   .bus_wdata  (bus_wdata),
   .sts_rdata  (sts_rdata),
   .xfer_ack   (xfer_ack),
   .xfer_noclr (xfer_noclr),
   .irq        (irq),
   .cnt_q      (cnt_q)
);

// File: tb/tmr_flag_unit_tb.sv
module tmr_flag_unit_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cnt_en, gr_wr, sts_rd, sts_wr, ien_wr, xfer_noclr;
   logic [1:0]   gr_wr_sel, gr_rd_sel;
   logic [W-1:0] gr_wdata, gr_rdata, cnt_q;
   logic [3:0]   gr_cap_mode, cap_in, xfer_ack;
   logic [7:0]   cap_edge_sel, sts_rdata;
   logic [4:0]   bus_wdata, irq;

   int nvec = 0;
   int nbad = 0;

   always #5 clk = ~clk;

   tmr_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gr_wr(gr_wr), .gr_wr_sel(gr_wr_sel),
      .gr_wdata(gr_wdata), .gr_rd_sel(gr_rd_sel), .gr_rdata(gr_rdata),
      .gr_cap_mode(gr_cap_mode), .cap_edge_sel(cap_edge_sel), .cap_in(cap_in),
      .sts_rd(sts_rd), .sts_wr(sts_wr), .ien_wr(ien_wr), .bus_wdata(bus_wdata),
      .sts_rdata(sts_rdata), .xfer_ack(xfer_ack), .xfer_noclr(xfer_noclr),
      .irq(irq), .cnt_q(cnt_q)
   );

   // ---------------- reference model, built from the requirements ----------------
   logic [W-1:0] m_cnt;
   logic [W-1:0] m_gr [4];
   logic [4:0]   m_flag, m_arm, m_ien;
   logic [3:0]   m_s1, m_s2, m_s3;
   logic [4:0]   ms, mc;
   logic [3:0]   mhit;

   function automatic logic sel_edge(logic [1:0] sel, logic cur, logic prev);
      if (sel == 2'b00)      return cur & ~prev;
      else if (sel == 2'b01) return ~cur & prev;
      else                   return cur ^ prev;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_flag <= '0; m_arm <= '0; m_ien <= '0;
         m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
         for (int i = 0; i < 4; i++) m_gr[i] <= '0;
      end else begin
         ms[4] = cnt_en && (m_cnt == 16'hFFFF);
         for (int i = 0; i < 4; i++) begin
            mhit[i] = gr_cap_mode[i] && sel_edge(cap_edge_sel[2*i +: 2], m_s2[i], m_s3[i]);
            ms[i]   = gr_cap_mode[i] ? mhit[i] : (cnt_en && m_cnt == m_gr[i]);
         end
         for (int i = 0; i < 5; i++) mc[i] = sts_wr && !bus_wdata[i] && m_arm[i];
         for (int i = 0; i < 4; i++) mc[i] = mc[i] || (xfer_ack[i] && !xfer_noclr);
         for (int i = 0; i < 4; i++) begin
            if (mhit[i]) m_gr[i] <= m_cnt;
            else if (gr_wr && gr_wr_sel == 2'(i)) m_gr[i] <= gr_wdata;
         end
         for (int i = 0; i < 5; i++) begin
            if (mc[i] && !ms[i]) m_arm[i] <= 1'b0;
            else if (sts_rd && m_flag[i]) m_arm[i] <= 1'b1;
         end
         m_flag <= ms | (m_flag & ~mc);
         m_s1 <= cap_in; m_s2 <= m_s1; m_s3 <= m_s2;
         if (ien_wr) m_ien <= bus_wdata;
         if (cnt_en) m_cnt <= m_cnt + 16'd1;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_model();
      chk("R5 sts_rdata vs model", 32'(sts_rdata), 32'({2'b11, 1'b0, m_flag}));
      chk("R9 irq vs model", 32'(irq), 32'(m_flag & m_ien));
      chk("R1 cnt_q vs model", 32'(cnt_q), 32'(m_cnt));
      chk("R11 gr_rdata vs model", 32'(gr_rdata), 32'(m_gr[gr_rd_sel]));
   endtask

   task automatic idle();
      cnt_en = 0; gr_wr = 0; sts_rd = 0; sts_wr = 0; ien_wr = 0;
      xfer_ack = '0; bus_wdata = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      check_model();
      idle();
   endtask

   initial begin
      #(150000 * 10);
      nbad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      rst_n = 0; idle();
      gr_wr_sel = '0; gr_wdata = '0; gr_rd_sel = '0; gr_cap_mode = '0;
      cap_edge_sel = '0; cap_in = '0; xfer_noclr = 0;
      repeat (3) @(negedge clk);
      chk("R10 reset status", 32'(sts_rdata), 32'h0C0);
      chk("R5 fixed bits", 32'(sts_rdata[7:5]), 32'h6);
      chk("R10 reset irq", 32'(irq), 0);
      chk("R10 reset counter", 32'(cnt_q), 0);
      chk("R10 reset register", 32'(gr_rdata), 0);
      rst_n = 1;
      tick();

      // R11 register write and readback
      gr_wr = 1; gr_wr_sel = 2; gr_wdata = 16'h1234; tick();
      gr_rd_sel = 2; tick();
      chk("R11 write/readback", 32'(gr_rdata), 32'h1234);

      // R1 counting; R3 matches at count 0 on registers 0,1,3
      for (int k = 0; k < 10; k++) begin cnt_en = 1; tick(); end
      tick();
      chk("R1 counter after 10 enables", 32'(cnt_q), 10);
      chk("R3 compare match at zero", 32'(sts_rdata), 32'h0CB);

      // R6 clear needs prior read; writing 1 does nothing
      sts_wr = 1; bus_wdata = 5'h00; tick(); tick();
      chk("R6 unread flags ignore 0-write", 32'(sts_rdata), 32'h0CB);
      sts_rd = 1; tick();
      sts_wr = 1; bus_wdata = 5'h1F; tick(); tick();
      chk("R6 write of 1 has no effect", 32'(sts_rdata), 32'h0CB);
      sts_wr = 1; bus_wdata = 5'h01; tick(); tick();
      chk("R6 armed flags cleared", 32'(sts_rdata), 32'h0C1);

      // R7 acknowledge clear and its disable
      xfer_noclr = 1; xfer_ack = 4'b0001; tick(); tick();
      chk("R7 ack ignored with noclr", 32'(sts_rdata), 32'h0C1);
      xfer_noclr = 0; xfer_ack = 4'b0001; tick(); tick();
      chk("R7 ack clears flag", 32'(sts_rdata), 32'h0C0);

      // R3 / R8: set beats clear on same edge
      gr_wr = 1; gr_wr_sel = 0; gr_wdata = 16'd10; tick();
      cnt_en = 1; tick(); tick();
      chk("R3 compare sets flag 0", 32'(sts_rdata), 32'h0C1);
      sts_rd = 1; tick();
      gr_wr = 1; gr_wr_sel = 0; gr_wdata = 16'd11; tick();
      cnt_en = 1; sts_wr = 1; bus_wdata = 5'h00; tick(); tick();
      chk("R8 set wins over clear", 32'(sts_rdata), 32'h0C1);
      sts_wr = 1; bus_wdata = 5'h00; tick(); tick();
      chk("R6 later 0-write clears", 32'(sts_rdata), 32'h0C0);

      // R9 interrupt gating
      ien_wr = 1; bus_wdata = 5'h1F; tick();
      gr_wr = 1; gr_wr_sel = 0; gr_wdata = 16'd12; tick();
      cnt_en = 1; tick(); tick();
      chk("R9 irq with enable", 32'(irq), 32'h01);
      ien_wr = 1; bus_wdata = 5'h00; tick(); tick();
      chk("R9 irq masked", 32'(irq), 0);
      chk("R9 flag kept while masked", 32'(sts_rdata), 32'h0C1);

      // R4 capture on register 1 (counter stopped at 13)
      gr_cap_mode = 4'b0010; cap_edge_sel = 8'h00; gr_rd_sel = 1;
      cap_in[1] = 1; tick(); tick(); tick(); tick();
      chk("R4 rising capture value", 32'(gr_rdata), 13);
      chk("R4 rising capture flag", 32'(sts_rdata), 32'h0C3);
      for (int k = 0; k < 5; k++) begin cnt_en = 1; tick(); end
      cap_edge_sel = 8'h04; cap_in[1] = 0; tick(); tick(); tick(); tick();
      chk("R4 falling capture value", 32'(gr_rdata), 18);
      for (int k = 0; k < 2; k++) begin cnt_en = 1; tick(); end
      cap_in[1] = 1; tick(); tick(); tick(); tick();
      chk("R4 rising edge ignored in falling mode", 32'(gr_rdata), 18);
      cap_edge_sel = 8'h08; cap_in[1] = 0; tick(); tick(); tick(); tick();
      chk("R4 both-edge capture value", 32'(gr_rdata), 20);

      // constrained random phase, checked against the model each cycle
      for (int k = 0; k < 6000; k++) begin
         cnt_en     = ($urandom % 4) != 0;
         sts_rd     = ($urandom % 10) < 3;
         sts_wr     = ($urandom % 8) == 0;
         ien_wr     = ($urandom % 20) == 0;
         bus_wdata  = 5'($urandom);
         gr_wr      = ($urandom % 10) == 0;
         gr_wr_sel  = 2'($urandom);
         gr_wdata   = m_cnt + 16'($urandom % 6);
         gr_rd_sel  = 2'($urandom);
         xfer_ack   = 4'($urandom) & 4'($urandom);
         if (($urandom % 50) == 0) xfer_noclr   = 1'($urandom);
         if (($urandom % 50) == 0) gr_cap_mode  = 4'($urandom);
         if (($urandom % 80) == 0) cap_edge_sel = 8'($urandom);
         if (($urandom % 5) == 0)  cap_in = cap_in ^ 4'(1 << ($urandom % 4));
         @(negedge clk);
         check_model();
      end

      // R2 wrap: clear wrap flag first, then run a full period
      idle(); gr_cap_mode = '0; xfer_noclr = 0;
      sts_rd = 1; tick();
      sts_wr = 1; bus_wdata = 5'h0F; tick(); tick();
      chk("R6 wrap flag cleared after read", 32'(sts_rdata[4]), 0);
      for (int k = 0; k < 65540; k++) begin cnt_en = 1; tick(); end
      tick();
      chk("R2 wrap flag set", 32'(sts_rdata[4]), 1);

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule